// File: doc/BRIEF.md
# Dual-Mode Processor Timer Bank

This block holds a bank of processor timers and one shared mode register. Each processor timer works in one of two modes. In counter mode it counts ticks up to a programmable limit, wraps to zero, sets a reached flag and raises that processor's interrupt. In user mode it is a free-standing 64-bit counter with no interrupt. Software starts and stops it and preloads it through two 32-bit halves. The counter's resolution is 0x200, so bits 8..0 of its value are always zero.

All registers are reached through one 32-bit register bus. A select field picks the target: select 0 is the system slot, which holds only the mode register, and select 1..NUM_PROC picks a processor timer. Word offsets inside a timer are:

- 0: limit, or the upper half in user mode
- 1: count, or the lower half in user mode
- 2: limit without a count reset
- 3: run control

The mode register sits at offset 4 of the system slot and has one bit per processor. A set bit means user mode. Writing it runs the switch sequence for every processor whose bit changes. A tick enable input advances every running timer by one step.

Top module: `dual_mode_timer`

## Requirements
- R1: After a synchronous active-low reset, every timer is in counter mode and running, with limit, count, reached and IRQ at zero, and the mode register reads 0.
- R2: In counter mode each tick adds 0x200 to the count. When count+0x200 reaches or passes the limit, the count goes to 0, the reached flag sets and the IRQ rises. A limit of 0 means the timer runs freely up to 0x7FFFFE00.
- R3: In counter mode a write to offset 0 stores bits 30..9 as the limit, clears the count and lowers the IRQ. A read of offset 0 returns the stored limit and clears both the reached flag and the IRQ.
- R4: In counter mode a write to offset 2 stores the limit in the same way and leaves the count as it is.
- R5: In counter mode a read of offset 1 returns the reached flag in bit 31 with the count in bits 30..9. Writes to offsets 1 and 3 have no effect, and offset 3 reads 1.
- R6: The mode register is bit p for processor p, at offset 4 of select 0. Bits at or above NUM_PROC are ignored and read 0. Offset 4 of a processor select reads 0 and ignores writes. Offsets 0..3 of select 0 read 0.
- R7: Setting a processor's mode bit lowers its IRQ and stops it, so offset 3 reads 0.
- R8: In user mode a write to offset 0 loads bits 30..0 as value bits 62..32. A write to offset 1 loads bits 31..9 as value bits 31..9. Either write clears the reached flag. Offset 0 reads the reached flag in bit 31 with value bits 62..32, and offset 1 reads value bits 31..0. Reads have no side effect.
- R9: In user mode, bit 0 of a write to offset 3 starts the timer when 1 and stops it when 0. Offset 3 reads the running bit. Ticks while stopped leave the value unchanged.
- R10: A running user timer adds 0x200 per tick, and the carry from the lower half passes into the upper half.
- R11: When a user timer reaches 0x7FFFFFFFFFFFFE00, its value wraps to 0 and the reached flag sets. Its IRQ stays low throughout user mode.
- R12: Clearing a mode bit returns that timer to counter mode, running, with count and reached at zero and the stored limit kept. A mode write whose bit is unchanged does nothing to that timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Advance every running timer by one step |
| bus_sel | input | $clog2(NUM_PROC+1) | 0 selects the system slot; p+1 selects processor p |
| bus_addr | input | 3 | Word offset inside the selected slot |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; needed for the read side effect |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current select and offset (combinational) |
| irq | output | NUM_PROC | Per-processor interrupt, level |

## Verification
The bench sweeps every processor through limits 1 to 5 and checks the count after each tick. A design with an off-by-one wrap point would fire one tick early or late, and one that ignores the low limit bits would wrap at the wrong place. It shrinks the limit below a running count through offset 2. A design that compares for equality would then run on toward the free-run ceiling and never fire. The user timer is preloaded just below the 32-bit boundary and just below the 64-bit ceiling. A design with a broken carry would leave the upper half unchanged. A design that raises an interrupt or loses the reached flag at the ceiling shows up at once, as does one where a read of the upper half clears that flag. Mode writes that leave a bit unchanged, and bits above the processor count, are checked for effect. A design that re-runs the switch sequence on every write would stop a running user timer.

// File: rtl/dmt_pkg.sv
// Shared constants for the dual-mode timer bank.
// Assumes a 32-bit register bus addressed in words.
package dmt_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned FRAC   = 9;                 // value bits that are always zero
    localparam int unsigned PER_W  = DATA_W - 1 - FRAC; // counter-mode period width (22)
    localparam int unsigned LO_W   = DATA_W - FRAC;     // stored bits of the lower half (23)
    localparam int unsigned HI_W   = DATA_W - 1;        // stored bits of the upper half (31)
    localparam int unsigned USR_W  = HI_W + LO_W;       // user value width in periods (54)

    localparam logic [2:0] OFF_LIMIT      = 3'd0;
    localparam logic [2:0] OFF_COUNT      = 3'd1;
    localparam logic [2:0] OFF_LIMIT_KEEP = 3'd2;
    localparam logic [2:0] OFF_RUN        = 3'd3;
    localparam logic [2:0] OFF_MODE       = 3'd4;
endpackage

// File: rtl/dmt_bus_decode.sv
// Register bus decoder and read multiplexer for the timer bank.
// Assumes select 0 is the system slot and select p+1 is processor p;
// selects beyond NUM_PROC read 0 and write nothing.
module dmt_bus_decode
    import dmt_pkg::*;
#(
    parameter int unsigned NUM_PROC = 4,
    parameter int unsigned SEL_W    = 3
) (
    input  logic [SEL_W-1:0]           sel,
    input  logic [2:0]                 addr,
    input  logic                       wr,
    input  logic                       rd,
    input  logic [NUM_PROC*DATA_W-1:0] tmr_rdata,
    input  logic [NUM_PROC-1:0]        mode_bits,
    output logic [NUM_PROC-1:0]        tmr_wr,
    output logic [NUM_PROC-1:0]        tmr_rd,
    output logic                       mode_wr,
    output logic [DATA_W-1:0]          rdata
);
    // Per-timer strobes: one-hot on the matching select.
    for (genvar g = 0; g < NUM_PROC; g++) begin : g_strobe
        assign tmr_wr[g] = wr && (sel == SEL_W'(g + 1));
        assign tmr_rd[g] = rd && (sel == SEL_W'(g + 1));
    end

    // Mode register write: system slot, offset 4 only.
    assign mode_wr = wr && (sel == '0) && (addr == OFF_MODE);

    // Read multiplexer over the system slot and the timers.
    always_comb begin
        rdata = '0;
        if (sel == '0) begin
            if (addr == OFF_MODE) rdata[NUM_PROC-1:0] = mode_bits;
        end else begin
            for (int i = 0; i < NUM_PROC; i++) begin
                if (sel == SEL_W'(i + 1)) rdata = tmr_rdata[i*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/dmt_mode_ctrl.sv
// Shared mode register: one bit per processor, 1 = user mode.
// Emits single-cycle switch pulses only for bits that change on a write.
// Assumes the write data is already narrowed to NUM_PROC bits.
module dmt_mode_ctrl #(
    parameter int unsigned NUM_PROC = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [NUM_PROC-1:0] wbits,
    output logic [NUM_PROC-1:0] mode,
    output logic [NUM_PROC-1:0] go_user,
    output logic [NUM_PROC-1:0] go_counter
);
    logic [NUM_PROC-1:0] mode_q;
    logic [NUM_PROC-1:0] flip;

    // Changed bits of this write, split by direction.
    always_comb begin
        flip       = wr_en ? (wbits ^ mode_q) : '0;
        go_user    = flip & wbits;
        go_counter = flip & ~wbits;
    end

    // Holds the mode bits; every processor starts in counter mode.
    always_ff @(posedge clk) begin
        if (!rst_n)     mode_q <= '0;
        else if (wr_en) mode_q <= wbits;
    end

    assign mode = mode_q;
endmodule

// File: rtl/dmt_proc_timer.sv
// One processor timer: limit counter with IRQ, or 64-bit user counter.
// Assumes wr_en/rd_en are already qualified for this timer. A mode switch
// pulse outranks a bus write, and a bus write outranks a tick.
module dmt_proc_timer
    import dmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              user_mode,
    input  logic              go_user,
    input  logic              go_counter,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              running
);
    logic [USR_W-1:0] cnt_q;
    logic [PER_W-1:0] lim_q;
    logic             reached_q;
    logic             irq_q;
    logic             run_q;
    logic [PER_W-1:0] lim_eff;
    logic [USR_W:0]   cnt_inc;
    logic [USR_W:0]   wrap_at;
    logic             hit;
    logic             adv;
    logic             rd_clr;

    // Wrap point for the current mode and the tick/read qualifiers.
    always_comb begin
        lim_eff = (lim_q == '0) ? '1 : lim_q;
        wrap_at = user_mode ? {1'b0, {USR_W{1'b1}}} : (USR_W + 1)'(lim_eff);
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        hit     = (cnt_inc >= wrap_at);
        adv     = tick_en && run_q;
        rd_clr  = rd_en && !user_mode && (addr == OFF_LIMIT);
    end

    // Timer state: switch sequence, register writes, then ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            lim_q     <= '0;
            reached_q <= 1'b0;
            irq_q     <= 1'b0;
            run_q     <= 1'b1;
        end else if (go_user) begin
            irq_q <= 1'b0;
            run_q <= 1'b0;
        end else if (go_counter) begin
            run_q     <= 1'b1;
            cnt_q     <= '0;
            reached_q <= 1'b0;
            irq_q     <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                OFF_LIMIT: begin
                    if (user_mode) begin
                        cnt_q[USR_W-1 -: HI_W] <= wdata[HI_W-1:0];
                        reached_q              <= 1'b0;
                    end else begin
                        lim_q <= wdata[FRAC +: PER_W];
                        cnt_q <= '0;
                        irq_q <= 1'b0;
                    end
                end
                OFF_COUNT: begin
                    if (user_mode) begin
                        cnt_q[LO_W-1:0] <= wdata[DATA_W-1 -: LO_W];
                        reached_q       <= 1'b0;
                    end
                end
                OFF_LIMIT_KEEP: begin
                    if (!user_mode) lim_q <= wdata[FRAC +: PER_W];
                end
                OFF_RUN: begin
                    if (user_mode) run_q <= wdata[0];
                end
                default: ;
            endcase
        end else begin
            if (adv) cnt_q <= hit ? '0 : cnt_inc[USR_W-1:0];
            if (adv && hit) begin
                reached_q <= 1'b1;
                if (!user_mode) irq_q <= 1'b1;
            end else if (rd_clr) begin
                reached_q <= 1'b0;
                irq_q     <= 1'b0;
            end
        end
    end

    // Register view for the current mode.
    always_comb begin
        rdata = '0;
        case (addr)
            OFF_LIMIT: rdata = user_mode ? {reached_q, cnt_q[USR_W-1 -: HI_W]}
                                         : {1'b0, lim_q, {FRAC{1'b0}}};
            OFF_COUNT: rdata = user_mode ? {cnt_q[LO_W-1:0], {FRAC{1'b0}}}
                                         : {reached_q, cnt_q[PER_W-1:0], {FRAC{1'b0}}};
            OFF_RUN:   rdata = {{(DATA_W-1){1'b0}}, run_q};
            default:   rdata = '0;
        endcase
    end

    assign irq     = irq_q;
    assign running = run_q;
endmodule

// File: rtl/dual_mode_timer.sv
// Top of the timer bank: bus decoder, shared mode register and one
// dual-mode timer per processor. Assumes 1 <= NUM_PROC <= 31 and at most
// one of bus_wr/bus_rd per cycle.
module dual_mode_timer
    import dmt_pkg::*;
#(
    parameter  int unsigned NUM_PROC = 4,
    localparam int unsigned SEL_W    = $clog2(NUM_PROC + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic [SEL_W-1:0]    bus_sel,
    input  logic [2:0]          bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_PROC-1:0] irq
);
    logic [NUM_PROC-1:0]        tmr_wr;
    logic [NUM_PROC-1:0]        tmr_rd;
    logic                       mode_wr;
    logic [NUM_PROC-1:0]        user_vec;
    logic [NUM_PROC-1:0]        to_user_vec;
    logic [NUM_PROC-1:0]        to_ctr_vec;
    logic [NUM_PROC-1:0]        run_vec;
    logic [NUM_PROC*DATA_W-1:0] tmr_rdata;

    dmt_bus_decode #(.NUM_PROC(NUM_PROC), .SEL_W(SEL_W)) u_decode (
        .sel       (bus_sel),
        .addr      (bus_addr),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .tmr_rdata (tmr_rdata),
        .mode_bits (user_vec),
        .tmr_wr    (tmr_wr),
        .tmr_rd    (tmr_rd),
        .mode_wr   (mode_wr),
        .rdata     (bus_rdata)
    );

    dmt_mode_ctrl #(.NUM_PROC(NUM_PROC)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (mode_wr),
        .wbits      (bus_wdata[NUM_PROC-1:0]),
        .mode       (user_vec),
        .go_user    (to_user_vec),
        .go_counter (to_ctr_vec)
    );

    for (genvar g = 0; g < NUM_PROC; g++) begin : g_tmr
        dmt_proc_timer u_tmr (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_en    (tick_en),
            .wr_en      (tmr_wr[g]),
            .rd_en      (tmr_rd[g]),
            .addr       (bus_addr),
            .wdata      (bus_wdata),
            .user_mode  (user_vec[g]),
            .go_user    (to_user_vec[g]),
            .go_counter (to_ctr_vec[g]),
            .rdata      (tmr_rdata[g*DATA_W +: DATA_W]),
            .irq        (irq[g]),
            .running    (run_vec[g])
        );
    end
endmodule

// File: rtl/dmt_checker.sv
// Temporal checks for the timer bank, bound to the top module.
module dmt_checker #(
    parameter int unsigned NUM_PROC = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick_en,
    input logic [NUM_PROC-1:0] irq,
    input logic [NUM_PROC-1:0] user_vec,
    input logic [NUM_PROC-1:0] run_vec,
    input logic [NUM_PROC-1:0] to_user_vec,
    input logic [NUM_PROC-1:0] to_ctr_vec
);
    // R1: the cycle after reset shows counter mode, running, IRQ low.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (irq == '0 && user_vec == '0 && run_vec == '1));

    for (genvar g = 0; g < NUM_PROC; g++) begin : g_chk
        // R2: an IRQ only rises after a tick.
        a_r2_irq_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[g]) |-> $past(tick_en));
        // R5: counter mode is always running.
        a_r5_counter_runs: assert property (@(posedge clk) disable iff (!rst_n)
            !user_vec[g] |-> run_vec[g]);
        // R7: entering user mode stops the timer and lowers its IRQ.
        a_r7_switch_stops: assert property (@(posedge clk) disable iff (!rst_n)
            to_user_vec[g] |=> (user_vec[g] && !run_vec[g] && !irq[g]));
        // R11: no interrupt while in user mode.
        a_r11_user_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
            user_vec[g] |-> !irq[g]);
        // R12: leaving user mode restarts the timer.
        a_r12_switch_runs: assert property (@(posedge clk) disable iff (!rst_n)
            to_ctr_vec[g] |=> (!user_vec[g] && run_vec[g]));
    end
endmodule

bind dual_mode_timer dmt_checker #(.NUM_PROC(NUM_PROC)) u_dmt_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .irq         (irq),
    .user_vec    (user_vec),
    .run_vec     (run_vec),
    .to_user_vec (to_user_vec),
    .to_ctr_vec  (to_ctr_vec)
);

// File: tb/tb_dual_mode_timer.sv
module tb_dual_mode_timer;
    localparam int NP = 4;
    localparam int SW = $clog2(NP + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic [SW-1:0] bus_sel = '0;
    logic [2:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dual_mode_timer #(.NUM_PROC(NP)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int s, input int a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = SW'(s); bus_addr = 3'(a); bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input int s, input int a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = SW'(s); bus_addr = 3'(a); bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic tk(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick_en = 1'b1;
            @(posedge clk);
            #1 tick_en = 1'b0;
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_up();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 irq", 32'(irq), 32'h0);
        rd(0, 4, v); check("R1 mode", v, 32'h0);
        for (int p = 0; p < NP; p++) begin
            rd(p + 1, 0, v); check("R1 limit", v, 32'h0);
            rd(p + 1, 1, v); check("R1 count", v, 32'h0);
            rd(p + 1, 3, v); check("R1 running", v, 32'h1);
        end

        // R2, R3: limit sweep on every processor, low bits carry junk
        for (int p = 0; p < NP; p++) begin
            for (int lim = 1; lim <= 5; lim++) begin
                wr(p + 1, 0, (32'(lim) << 9) | 32'((lim * 37) & 'h1FF));
                for (int k = 1; k < lim; k++) begin
                    tk(1);
                    check("R2 no irq yet", 32'(irq[p]), 32'h0);
                    rd(p + 1, 1, v); check("R2 count step", v, 32'(k) << 9);
                end
                tk(1);
                check("R2 irq at limit", 32'(irq[p]), 32'h1);
                rd(p + 1, 1, v); check("R2 reached wrap", v, 32'h8000_0000);
                rd(p + 1, 0, v); check("R3 limit read", v, 32'(lim) << 9);
                check("R3 read clears irq", 32'(irq[p]), 32'h0);
                rd(p + 1, 1, v); check("R3 read clears reached", v, 32'h0);
            end
        end

        // R3: limit masking
        wr(1, 0, 32'hFFFF_FFFF);
        rd(1, 0, v); check("R3 limit mask", v, 32'h7FFF_FE00);

        // R2: free-run with limit 0
        wr(1, 0, 32'h0);
        tk(7);
        rd(1, 1, v); check("R2 free run count", v, 32'h0000_0E00);
        check("R2 free run no irq", 32'(irq[0]), 32'h0);

        // R4: offset 2 keeps count, then wraps at the new limit
        wr(1, 2, 32'h0000_1000);
        rd(1, 1, v); check("R4 count kept", v, 32'h0000_0E00);
        tk(1);
        check("R4 irq at new limit", 32'(irq[0]), 32'h1);
        rd(1, 0, v); check("R4 limit value", v, 32'h0000_1000);
        wr(1, 0, 32'h0);
        tk(6);
        wr(1, 2, 32'h0000_0600);
        tk(1);
        check("R4 limit below count wraps", 32'(irq[0]), 32'h1);
        rd(1, 1, v); check("R4 wrap count", v, 32'h8000_0000);
        rd(1, 0, v);

        // R5: counter-mode writes to offsets 1 and 3 ignored
        wr(1, 1, 32'h1234_5600);
        wr(1, 3, 32'h0);
        rd(1, 1, v); check("R5 count write ignored", v, 32'h0);
        rd(1, 3, v); check("R5 still running", v, 32'h1);
        tk(1);
        rd(1, 1, v); check("R5 keeps counting", v, 32'h0000_0200);

        // R6: mode register reach and width
        wr(0, 4, 32'hFFFF_FFF0);
        rd(0, 4, v); check("R6 high bits ignored", v, 32'h0);
        wr(1, 4, 32'h1);
        rd(0, 4, v); check("R6 processor write ignored", v, 32'h0);
        rd(1, 4, v); check("R6 processor read zero", v, 32'h0);
        for (int a = 0; a < 4; a++) begin
            rd(0, a, v); check("R6 system slot zero", v, 32'h0);
        end

        // R7: switch processor 1 to user mode while its IRQ is high
        wr(2, 0, 32'h0000_0200);
        tk(1);
        check("R7 irq set before switch", 32'(irq[1]), 32'h1);
        wr(0, 4, 32'h2);
        rd(0, 4, v); check("R7 mode bit", v, 32'h2);
        check("R7 irq lowered", 32'(irq[1]), 32'h0);
        rd(2, 3, v); check("R7 stopped", v, 32'h0);

        // R8: preload halves
        wr(2, 1, 32'hFFFF_FFFF);
        wr(2, 0, 32'hFFFF_FFF5);
        rd(2, 0, v); check("R8 upper", v, 32'h7FFF_FFF5);
        rd(2, 1, v); check("R8 lower", v, 32'hFFFF_FE00);

        // R9: stopped timer ignores ticks, then start
        tk(3);
        rd(2, 1, v); check("R9 stopped lower", v, 32'hFFFF_FE00);
        wr(2, 3, 32'h1);
        rd(2, 3, v); check("R9 started", v, 32'h1);

        // R10: carry into the upper half
        tk(1);
        rd(2, 0, v); check("R10 carry upper", v, 32'h7FFF_FFF6);
        rd(2, 1, v); check("R10 carry lower", v, 32'h0);
        tk(3);
        rd(2, 1, v); check("R10 lower step", v, 32'h0000_0600);

        // R9: stop with bit 0 clear
        wr(2, 3, 32'hFFFF_FFFE);
        tk(2);
        rd(2, 1, v); check("R9 stop holds", v, 32'h0000_0600);
        rd(2, 3, v); check("R9 stopped status", v, 32'h0);

        // R11: ceiling wrap sets reached, no IRQ
        wr(2, 0, 32'h7FFF_FFFF);
        wr(2, 1, 32'hFFFF_FC00);
        wr(2, 3, 32'h1);
        tk(1);
        check("R11 no irq", 32'(irq[1]), 32'h0);
        rd(2, 0, v); check("R11 reached upper", v, 32'h8000_0000);
        rd(2, 1, v); check("R11 wrap lower", v, 32'h0);
        rd(2, 0, v); check("R8 read keeps reached", v, 32'h8000_0000);
        wr(2, 1, 32'h0000_0200);
        rd(2, 0, v); check("R8 write clears reached", v, 32'h0);

        // R12: same-bit rewrite does nothing
        wr(0, 4, 32'h2);
        rd(2, 3, v); check("R12 unchanged bit keeps running", v, 32'h1);
        rd(2, 1, v); check("R12 unchanged bit keeps value", v, 32'h0000_0200);

        // R12: back to counter mode
        wr(0, 4, 32'h0);
        rd(2, 3, v); check("R12 running again", v, 32'h1);
        rd(2, 1, v); check("R12 count cleared", v, 32'h0);
        rd(2, 0, v); check("R12 limit kept", v, 32'h0000_0200);

        // R7, R12: walk user mode across every processor
        for (int p = 0; p < NP; p++) begin
            wr(0, 4, 32'(1) << p);
            rd(0, 4, v); check("R7 walk mode", v, 32'(1) << p);
            for (int q = 0; q < NP; q++) begin
                rd(q + 1, 3, v);
                check((q == p) ? "R7 walk stopped" : "R12 walk running",
                      v, (q == p) ? 32'h0 : 32'h1);
            end
            check("R11 walk no irq", 32'(irq[p]), 32'h0);
        end

        finish_up();
    end
endmodule